// File: doc/BRIEF.md
# Dual-Channel DAC Staging Register Core

This block is the digital register core of a two-channel DAC. A serial front end shifts in a 16-bit command word and presents it with a one-cycle execute strobe. Each channel has two registers. A staging (input) register holds a pending code. An output register drives the converter. Some commands change only a staging register, so software can set up a new value on one channel without moving either analog output.

An asynchronous active-low load pin, once synchronized, moves both staging registers into their output registers in the same cycle. A single update command can also write both levels of both channels at once. Out of reset, every register holds the midscale code.

Top module: `dual_dac_regs`

## Requirements
- R1: After reset all four registers hold midscale, 0x200 with the default 10-bit width. This shows on both outputs, and a transfer before any command leaves 0x200 on both.
- R2: When the strobe is high and command bits 15:13 are 011, both staging and both output registers take bits 12:3. Both outputs show the value after the next rising edge.
- R3: Command bits 15:13 = 001 writes bits 12:3 into the channel A staging register only. Neither output changes.
- R4: Command bits 15:13 = 101 writes bits 12:3 into the channel B staging register only. Neither output changes.
- R5: The all-zero command and every code other than 011, 001 and 101 change no register. This is visible after a later transfer.
- R6: Command bits 2:0 have no effect on any register.
- R7: A falling edge on `load_n` copies both staging registers into the output registers. It passes through SYNC_STAGES flops first, so with two stages the outputs change on the third rising edge after `load_n` goes low.
- R8: Holding `load_n` low causes exactly one transfer. Staging writes made while it stays low do not reach the outputs.
- R9: If a strobed command and a transfer fall in the same cycle, the command updates the staging registers first. The transfer then moves the updated values.
- R10: While the strobe is low, the command bus is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, restores midscale |
| cmd_valid | input | 1 | Execute strobe, one cycle per command |
| cmd | input | 16 | Command word: code 15:13, data 12:3, 2:0 unused |
| load_n | input | 1 | Asynchronous active-low transfer pin |
| dac_a | output | 10 | Channel A output register code |
| dac_b | output | 10 | Channel B output register code |

## Verification
The bench builds the core with its defaults: a 10-bit code, a 16-bit command and a two-flop synchronizer. These values put midscale at 0x200 and fix the pin-to-output latency at three edges. That latency lets the bench place a strobe in the exact cycle the transfer fires, to test the ordering rule. Random command mixes, including undefined codes and commands with the strobe low, are interleaved with pin pulses. The staging contents can only be seen through a transfer, so every write reaches a check.

// File: rtl/dual_dac_regs.sv
module dual_dac_regs #(
  parameter int DATA_W      = 10,
  parameter int CMD_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              load_n,
  output logic [DATA_W-1:0] dac_a,
  output logic [DATA_W-1:0] dac_b
);
  localparam int CODE_W   = 3;
  localparam int CODE_LSB = CMD_W - CODE_W;
  localparam int DATA_LSB = CODE_LSB - DATA_W;
  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);
  localparam logic [CODE_W-1:0] OP_BOTH = 3'b011;
  localparam logic [CODE_W-1:0] OP_A    = 3'b001;
  localparam logic [CODE_W-1:0] OP_B    = 3'b101;

  logic [CODE_W-1:0] code;
  logic [DATA_W-1:0] data;
  logic              unused_lsbs;
  assign code        = cmd[CMD_W-1:CODE_LSB];
  assign data        = cmd[CODE_LSB-1:DATA_LSB];
  assign unused_lsbs = ^cmd[DATA_LSB-1:0];

  logic [SYNC_STAGES-1:0] ld_sync;
  logic                   ld_prev;
  logic                   xfer;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ld_sync <= '1;
      ld_prev <= 1'b1;
    end else begin
      ld_sync <= {ld_sync[SYNC_STAGES-2:0], load_n};
      ld_prev <= ld_sync[SYNC_STAGES-1];
    end
  assign xfer = ld_prev & ~ld_sync[SYNC_STAGES-1];

  logic              wr_both, wr_a, wr_b;
  logic [DATA_W-1:0] stg_a, stg_b, stg_a_nx, stg_b_nx;
  assign wr_both  = cmd_valid && code == OP_BOTH;
  assign wr_a     = cmd_valid && code == OP_A;
  assign wr_b     = cmd_valid && code == OP_B;
  assign stg_a_nx = (wr_both || wr_a) ? data : stg_a;
  assign stg_b_nx = (wr_both || wr_b) ? data : stg_b;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stg_a <= MID;
      stg_b <= MID;
      dac_a <= MID;
      dac_b <= MID;
    end else begin
      stg_a <= stg_a_nx;
      stg_b <= stg_b_nx;
      if (xfer || wr_both) begin
        dac_a <= stg_a_nx;
        dac_b <= stg_b_nx;
      end
    end

  a_r2_both_update: assert property (@(posedge clk) disable iff (!rst_n)
    wr_both |=> dac_a == $past(data) && dac_b == $past(data));
  a_r3_a_only_holds_out: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a && !xfer |=> $stable(dac_a) && $stable(dac_b));
  a_r4_b_only_holds_out: assert property (@(posedge clk) disable iff (!rst_n)
    wr_b && !xfer |=> $stable(dac_a) && $stable(dac_b));
  a_r7_xfer_copies: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && !cmd_valid |=> dac_a == $past(stg_a) && dac_b == $past(stg_b));
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> !xfer);
  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid && !xfer |=> $stable(dac_a) && $stable(dac_b) && $stable(stg_a) && $stable(stg_b));
endmodule

// File: tb/tb_dual_dac_regs.sv
module tb_dual_dac_regs;
  logic        clk = 0, rst_n = 0, cmd_valid = 0, load_n = 1;
  logic [15:0] cmd = '0;
  logic [9:0]  dac_a, dac_b;
  int n_cmp = 0, n_bad = 0;
  logic [9:0] m_sa, m_sb, m_oa, m_ob;

  dual_dac_regs dut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
                     .load_n(load_n), .dac_a(dac_a), .dac_b(dac_b));

  always #2 clk = ~clk;

  function automatic logic [15:0] mk(input logic [2:0] c, input logic [9:0] d, input logic [2:0] l);
    return {c, d, l};
  endfunction

  task automatic chk(input string rq, input logic [9:0] ea, input logic [9:0] eb);
    n_cmp++;
    if (dac_a !== ea || dac_b !== eb) begin
      n_bad++;
      $display("FAIL %s: a=%h b=%h expected a=%h b=%h", rq, dac_a, dac_b, ea, eb);
    end
  endtask

  task automatic model_cmd(input logic v, input logic [15:0] c);
    if (!v) return;
    case (c[15:13])
      3'b011: begin m_sa = c[12:3]; m_sb = c[12:3]; m_oa = c[12:3]; m_ob = c[12:3]; end
      3'b001: m_sa = c[12:3];
      3'b101: m_sb = c[12:3];
      default: ;
    endcase
  endtask

  task automatic do_cmd(input string rq, input logic v, input logic [15:0] c);
    @(negedge clk); cmd_valid = v; cmd = c;
    model_cmd(v, c);
    @(negedge clk); cmd_valid = 0; cmd = $urandom;
    chk(rq, m_oa, m_ob);
  endtask

  task automatic do_load(input string rq);
    @(negedge clk); load_n = 0;
    repeat (4) @(negedge clk);
    m_oa = m_sa; m_ob = m_sb;
    chk(rq, m_oa, m_ob);
    load_n = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #400000;
    n_bad++; n_cmp++;
    $display("FAIL watchdog: a=%h b=%h expected completion", dac_a, dac_b);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    m_sa = 10'h200; m_sb = 10'h200; m_oa = 10'h200; m_ob = 10'h200;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset outputs", 10'h200, 10'h200);
    do_load("R1 reset staging");

    do_cmd("R2 both", 1, mk(3'b011, 10'h3FF, 3'b000));
    do_cmd("R3 stage A", 1, mk(3'b001, 10'h000, 3'b000));
    do_cmd("R4 stage B", 1, mk(3'b101, 10'h155, 3'b000));
    do_cmd("R5 zero no-op", 1, 16'h0000);
    do_cmd("R5 undefined code", 1, mk(3'b111, 10'h0AA, 3'b101));
    do_cmd("R10 strobe low", 0, mk(3'b011, 10'h011, 3'b000));
    do_load("R3 R4 R5 R10 transfer shows staging");
    do_cmd("R6 low bits", 1, mk(3'b011, 10'h123, 3'b111));

    // R8: held low, later staging must not reach outputs
    @(negedge clk); load_n = 0;
    do_cmd("R3 stage before edge", 1, mk(3'b001, 10'h2AB, 3'b000));
    repeat (3) @(negedge clk);
    m_oa = m_sa; m_ob = m_sb;
    chk("R7 transfer", m_oa, m_ob);
    do_cmd("R8 stage while low", 1, mk(3'b101, 10'h0F0, 3'b000));
    repeat (4) @(negedge clk);
    chk("R8 single transfer", m_oa, m_ob);
    load_n = 1;
    repeat (3) @(negedge clk);

    // R7 exact latency and R9 same-cycle ordering
    @(negedge clk); load_n = 0;
    @(negedge clk);
    chk("R7 not before edge 3", m_oa, m_ob);
    @(negedge clk);
    cmd_valid = 1; cmd = mk(3'b001, 10'h3C3, 3'b010);
    chk("R7 not before edge 3b", m_oa, m_ob);
    m_sa = 10'h3C3;
    @(negedge clk);
    cmd_valid = 0;
    m_oa = m_sa; m_ob = m_sb;
    chk("R9 command then transfer", m_oa, m_ob);
    load_n = 1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 300; i++) begin
      logic [2:0] c;
      logic       v;
      int         p;
      p = $urandom % 6;
      v = 1;
      case (p)
        0: c = 3'b011;
        1: c = 3'b001;
        2: c = 3'b101;
        3: c = 3'b000;
        4: begin c = 3'($urandom); if (c == 3'b011 || c == 3'b001 || c == 3'b101) c = 3'b110; end
        default: begin c = 3'($urandom); v = 0; end
      endcase
      do_cmd("R2 R3 R4 R5 R10 random", v, mk(c, 10'($urandom), 3'($urandom)));
      if (i % 7 == 6) do_load("R7 random transfer");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule